// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between the write-cycle capture logic and the page-load engines of a multi-lane byte-wide non-volatile memory. Each captured write presents a lane number, a 17-bit address and an 8-bit data byte. The block decides whether that byte may reach the lane's page buffer (`acc_o`), or must be dropped while a dummy busy period is started (`dum_o`). It also keeps one protect flag per lane.

The block recognises two command sequences, each a fixed series of address/data writes:

- A three-write unlock prefix. It opens a load window and arms protection for the lane.
- A six-write disable sequence. It opens a load window and disarms protection.

In both cases, the new flag value takes effect when the page engine signals the close of that lane's load window (`win_end_i`). This holds even if no data byte was loaded after the sequence. Command bytes are never forwarded to the array.

While a lane is protected, only bytes that follow the prefix are accepted. Any other write is suppressed, but it still triggers a busy period, so software sees the same timing. The protect flags model non-volatile state. They power up cleared and are not touched by `rst_n`.

Top module: `wp_seq`

## Requirements
- R1: The unlock prefix is data AAh at address 05555h, then 55h at 02AAAh, then A0h at 05555h, all to the same lane. No write that matches a step of either sequence produces an `acc_o` or `dum_o` pulse.
- R2: After a complete prefix, every write to that lane is accepted until its `win_end_i` bit is seen. At that edge `prot_o` for the lane becomes 1, whether it was 0 or 1 before.
- R3: The disable sequence is AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, 20h@05555h. The writes after it are accepted, and `prot_o` for the lane becomes 0 at the next `win_end_i` for that lane.
- R4: A data write to a protected lane outside a load window gives a one-cycle `dum_o` pulse for that lane in the cycle after the write, and no `acc_o` pulse.
- R5: After power-up, `prot_o` is 0. A data write to an unprotected lane gives a one-cycle `acc_o` pulse for that lane in the cycle after the write. `acc_o` and `dum_o` are 0 during reset.
- R6: `rst_n` clears sequence progress and output pulses, but never changes `prot_o`. A lane protected before reset still suppresses writes after it.
- R7: Lanes are independent. Outputs pulse only on the bit of the addressed lane, and one lane's writes never alter another lane's flag or sequence state.
- R8: A write that fails to match the next step of a sequence aborts the sequence. That write is then judged as if no sequence were in progress: AAh@05555h starts step one again, and any other write is a data write under R4/R5.
- R9: A `win_end_i` pulse for a lane whose sequence is only partly entered discards that progress.
- R10: When a write and `win_end_i` reach the same lane in one cycle, the window close is applied first. The write is judged against the updated flag with no sequence in progress.
- R11: `acc_o` and `dum_o` never pulse together on one lane, and at most one lane pulses either output in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of sequence state and pulses |
| wr_vld_i | input | 1 | A captured write cycle is present this cycle |
| wr_lane_i | input | 2 | Lane addressed by the write |
| wr_addr_i | input | 17 | Byte address within the lane |
| wr_data_i | input | 8 | Write data byte |
| win_end_i | input | 4 | Per-lane pulse: the lane's page-load window has closed |
| acc_o | output | 4 | Per-lane pulse: byte forwarded to the page buffer |
| dum_o | output | 4 | Per-lane pulse: byte suppressed, dummy busy period started |
| prot_o | output | 4 | Per-lane protect flag |

## Verification
The close of a lane's load window and a new write to that same lane can land in one cycle. In that case the flag update and the judgement of the write interact.

The bench arms a lane with the prefix, then drives its `win_end_i` together with a plain data write. It expects the flag to rise and the same write to be suppressed with a dummy pulse, because the window close wins.

The abort paths are also walked with the flag set. A broken prefix must turn its breaking write into a dummy pulse, while a repeated AAh@05555h must silently restart matching.

// File: rtl/wp_seq.sv
module wp_seq #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int LANES = 4,
  parameter logic [AW-1:0] KEY_A = 17'h05555,
  parameter logic [AW-1:0] KEY_B = 17'h02AAA,
  parameter logic [DW-1:0] D_AA = 8'hAA,
  parameter logic [DW-1:0] D_55 = 8'h55,
  parameter logic [DW-1:0] D_ON = 8'hA0,
  parameter logic [DW-1:0] D_OFF1 = 8'h80,
  parameter logic [DW-1:0] D_OFF2 = 8'h20,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld_i,
  input  logic [LW-1:0]    wr_lane_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LANES-1:0] win_end_i,
  output logic [LANES-1:0] acc_o,
  output logic [LANES-1:0] dum_o,
  output logic [LANES-1:0] prot_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_K3, S_K4, S_K5, S_LON, S_LOFF
  } st_e;

  logic k_aa, k_55, k_on, k_off1, k_off2;

  assign k_aa   = (wr_addr_i == KEY_A) && (wr_data_i == D_AA);
  assign k_55   = (wr_addr_i == KEY_B) && (wr_data_i == D_55);
  assign k_on   = (wr_addr_i == KEY_A) && (wr_data_i == D_ON);
  assign k_off1 = (wr_addr_i == KEY_A) && (wr_data_i == D_OFF1);
  assign k_off2 = (wr_addr_i == KEY_A) && (wr_data_i == D_OFF2);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    st_e  st_q, st_base, st_d;
    logic prot_q = 1'b0;
    logic prot_eff, hit, fresh, acc_d, dum_d, acc_q, dum_q;

    assign hit = wr_vld_i && (wr_lane_i == LW'(g));

    always_comb begin
      st_base  = win_end_i[g] ? S_IDLE : st_q;
      prot_eff = prot_q;
      if (win_end_i[g] && st_q == S_LON)  prot_eff = 1'b1;
      if (win_end_i[g] && st_q == S_LOFF) prot_eff = 1'b0;
      st_d  = st_base;
      acc_d = 1'b0;
      dum_d = 1'b0;
      fresh = 1'b0;
      if (hit) begin
        case (st_base)
          S_K1: if (k_55) st_d = S_K2; else fresh = 1'b1;
          S_K2: begin
            if (k_on)        st_d = S_LON;
            else if (k_off1) st_d = S_K3;
            else             fresh = 1'b1;
          end
          S_K3: if (k_aa)   st_d = S_K4;   else fresh = 1'b1;
          S_K4: if (k_55)   st_d = S_K5;   else fresh = 1'b1;
          S_K5: if (k_off2) st_d = S_LOFF; else fresh = 1'b1;
          S_LON, S_LOFF: acc_d = 1'b1;
          default: fresh = 1'b1;
        endcase
        if (fresh) begin
          if (k_aa) begin
            st_d = S_K1;
          end else begin
            st_d  = S_IDLE;
            acc_d = !prot_eff;
            dum_d = prot_eff;
          end
        end
      end
    end

    always_ff @(posedge clk) prot_q <= prot_eff;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= S_IDLE;
        acc_q <= 1'b0;
        dum_q <= 1'b0;
      end else begin
        st_q  <= st_d;
        acc_q <= acc_d;
        dum_q <= dum_d;
      end
    end

    assign acc_o[g]  = acc_q;
    assign dum_o[g]  = dum_q;
    assign prot_o[g] = prot_q;
  end

endmodule

// File: rtl/wp_seq_chk.sv
module wp_seq_chk #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_vld_i,
  input logic [LW-1:0]    wr_lane_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [LANES-1:0] win_end_i,
  input logic [LANES-1:0] acc_o,
  input logic [LANES-1:0] dum_o,
  input logic [LANES-1:0] prot_o
);

  a_r11_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(acc_o | dum_o) <= 1);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_o[g] && dum_o[g]));

    a_r4_dum_prot: assert property (@(posedge clk) disable iff (!rst_n)
      dum_o[g] |-> prot_o[g]);

    a_r7_source: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_o[g] || dum_o[g]) |-> $past(wr_vld_i && (wr_lane_i == LW'(g))));

    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(win_end_i[g]) |-> $stable(prot_o[g]));
  end

endmodule

bind wp_seq wp_seq_chk #(.AW(AW), .DW(DW), .LANES(LANES)) chk_i (.*);

// File: tb/wp_seq_tb_top.sv
module wp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_vld_i = 1'b0;
  logic [1:0]  wr_lane_i = '0;
  logic [16:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [3:0]  win_end_i = '0;
  logic [3:0]  acc_o, dum_o, prot_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_vld_i(wr_vld_i), .wr_lane_i(wr_lane_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .win_end_i(win_end_i),
    .acc_o(acc_o), .dum_o(dum_o), .prot_o(prot_o)
  );

  typedef struct packed {
    logic        vld;
    logic [3:0]  wend;
    logic [1:0]  lane;
    logic [16:0] addr;
    logic [7:0]  data;
    logic [3:0]  eacc;
    logic [3:0]  edum;
    logic [3:0]  eprot;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h0, 2'd0, 17'h00100, 8'h11, 4'h1, 4'h0, 4'h0, 4'd5},  // R5 plain write
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h0, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h0, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hA0, 4'h0, 4'h0, 4'h0, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h00200, 8'h22, 4'h1, 4'h0, 4'h0, 4'd2},  // R2 load
    '{1'b0, 4'h1, 2'd0, 17'h00000, 8'h00, 4'h0, 4'h0, 4'h1, 4'd2},  // R2 arm
    '{1'b1, 4'h0, 2'd0, 17'h00300, 8'h33, 4'h0, 4'h1, 4'h1, 4'd4},  // R4
    '{1'b1, 4'h0, 2'd1, 17'h00300, 8'h44, 4'h2, 4'h0, 4'h1, 4'd7},  // R7
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h1, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hA0, 4'h0, 4'h0, 4'h1, 4'd1},  // R1
    '{1'b1, 4'h0, 2'd0, 17'h00400, 8'h55, 4'h1, 4'h0, 4'h1, 4'd2},  // R2
    '{1'b0, 4'h1, 2'd0, 17'h00000, 8'h00, 4'h0, 4'h0, 4'h1, 4'd2},  // R2
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h12, 4'h0, 4'h1, 4'h1, 4'd8},  // R8 break
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd8},  // R8 restart
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hA0, 4'h0, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b1, 4'h0, 2'd0, 17'h00500, 8'h66, 4'h1, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b0, 4'h1, 2'd0, 17'h00000, 8'h00, 4'h0, 4'h0, 4'h1, 4'd8},  // R8
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'h80, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h05555, 8'h20, 4'h0, 4'h0, 4'h1, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd0, 17'h00600, 8'h77, 4'h1, 4'h0, 4'h1, 4'd3},  // R3 load
    '{1'b0, 4'h1, 2'd0, 17'h00000, 8'h00, 4'h0, 4'h0, 4'h0, 4'd3},  // R3 disarm
    '{1'b1, 4'h0, 2'd0, 17'h00700, 8'h88, 4'h1, 4'h0, 4'h0, 4'd3},  // R3
    '{1'b1, 4'h0, 2'd2, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h0, 4'd9},  // R9
    '{1'b0, 4'h4, 2'd0, 17'h00000, 8'h00, 4'h0, 4'h0, 4'h0, 4'd9},  // R9 close
    '{1'b1, 4'h0, 2'd2, 17'h02AAA, 8'h55, 4'h4, 4'h0, 4'h0, 4'd9},  // R9 now data
    '{1'b1, 4'h0, 2'd3, 17'h05555, 8'hAA, 4'h0, 4'h0, 4'h0, 4'd10}, // R10
    '{1'b1, 4'h0, 2'd3, 17'h02AAA, 8'h55, 4'h0, 4'h0, 4'h0, 4'd10}, // R10
    '{1'b1, 4'h0, 2'd3, 17'h05555, 8'hA0, 4'h0, 4'h0, 4'h0, 4'd10}, // R10
    '{1'b1, 4'h8, 2'd3, 17'h0007F, 8'h99, 4'h0, 4'h8, 4'h8, 4'd10}  // R10 same cycle
  };

  task automatic chk(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] lane, input logic [16:0] addr, input logic [7:0] data);
    wr_vld_i = 1'b1; wr_lane_i = lane; wr_addr_i = addr; wr_data_i = data; win_end_i = '0;
    @(posedge clk); @(negedge clk);
    wr_vld_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(5, "reset acc", acc_o, 4'h0);   // R5
    chk(5, "reset dum", dum_o, 4'h0);   // R5
    chk(5, "power-up prot", prot_o, 4'h0);  // R5
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr_vld_i = VEC[i].vld; wr_lane_i = VEC[i].lane; wr_addr_i = VEC[i].addr;
      wr_data_i = VEC[i].data; win_end_i = VEC[i].wend;
      @(posedge clk); @(negedge clk);
      chk(int'(VEC[i].req), $sformatf("step %0d acc", i), acc_o, VEC[i].eacc);
      chk(int'(VEC[i].req), $sformatf("step %0d dum", i), dum_o, VEC[i].edum);
      chk(int'(VEC[i].req), $sformatf("step %0d prot", i), prot_o, VEC[i].eprot);
      chk(11, $sformatf("step %0d overlap", i), acc_o & dum_o, 4'h0);  // R11
    end
    wr_vld_i = 1'b0; win_end_i = '0;
    // R6: reset must leave the flags alone and drop partial progress
    wr(2'd1, 17'h05555, 8'hAA);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(6, "prot during reset", prot_o, 4'h8);
    chk(6, "acc during reset", acc_o, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd3, 17'h00010, 8'h01);
    chk(6, "lane3 after reset dum", dum_o, 4'h8);
    wr(2'd1, 17'h02AAA, 8'h55);
    chk(6, "lane1 progress cleared acc", acc_o, 4'h2);
    wr(2'd0, 17'h00020, 8'h02);
    chk(5, "lane0 after reset acc", acc_o, 4'h1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule